// File: doc/BRIEF.md
# Event Class Queue Sorter

This block takes one pulse-height event per clock, each carrying a 3-bit class tag, a data word and three anomaly flags. It sorts it into one of four first-in-first-out queues. Class 0 holds events that stop in the first detector layer. Class 1 holds events that stop in a deeper layer. Class 2 holds penetrating events and class 3 holds pulser stimulation events. Downstream logic drains each queue through its own pop strobe and sees the oldest entry on that queue's read data output.

Next to the queues, the block keeps a set of saturating counters:
- a total of all events received;
- one count per class, which includes events that a full queue refused;
- three anomaly counts, for duplicated first-layer pulse heights, a first readout that is not from the first layer, and layers read out of order.

Each queue has a sticky overflow bit. A frame-clear strobe empties every queue and zeroes every counter and overflow bit in one cycle.

Each queue is controlled by a small state machine with three states:
- `Q_EMPTY`: no entries are stored.
- `Q_HOLDING`: between one and DEPTH-1 entries are stored.
- `Q_FULL`: DEPTH entries are stored.

The machine has these transitions:
- FILL (`Q_EMPTY`→`Q_HOLDING`): a push arrives while the queue is empty.
- TOP (`Q_HOLDING`→`Q_FULL`): a push without a pop arrives while DEPTH-1 entries are stored.
- DRAIN (`Q_HOLDING`→`Q_EMPTY`): a pop without a push arrives while one entry is stored.
- RELIEVE (`Q_FULL`→`Q_HOLDING`): a pop arrives while the queue is full.
- FLUSH (any state→`Q_EMPTY`): the frame-clear strobe is high.

Top module: `evs_sorter`

## Requirements
- R1: An event with `evt_valid` high and class code 0, 1, 2 or 3 is written to the queue with that index. Class codes 4 to 7 are invalid (3'b111 is the normal invalid code) and are written to no queue.
- R2: Each queue returns entries in arrival order. While a queue is not empty, its slice of `q_rdata` (bits [24*i+23:24*i]) shows the oldest entry. A pop removes that entry at the next clock edge, and all results of an event or pop are visible after the clock edge that samples it.
- R3: A queue holds DEPTH (16) entries. An event for a full queue is dropped and the stored contents stay unchanged, even when that queue is popped in the same cycle.
- R4: A queue's overflow bit in `q_ovf` sets on its first dropped event. It stays set through later pops until frame clear.
- R5: `total_cnt` increases by one for every accepted event, whatever its class code.
- R6: The class counter for class i (slice i of `class_cnt`) increases for every accepted event of class i, including events that are dropped.
- R7: `dup_cnt`, `lead_cnt` and `skip_cnt` each increase by one for every accepted event that has `evt_dup_l1`, `evt_lead_not_l1` or `evt_layer_skip` set, respectively. The three counters are independent of each other.
- R8: Every counter stops at all-ones and does not wrap.
- R9: A `frame_clr` pulse empties all queues and zeroes all counters and overflow bits. An event or pop in the same cycle is discarded: it is not counted and it is not queued.
- R10: A pop of an empty queue is ignored. The queue still accepts and returns the next event correctly, including a push and a pop to the same empty queue in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clr | input | 1 | Frame clear strobe |
| evt_valid | input | 1 | Event present this cycle |
| evt_class | input | 3 | Class tag (0..3 queued, 4..7 invalid) |
| evt_data | input | DATA_W | Event payload |
| evt_dup_l1 | input | 1 | Duplicated first-layer pulse height flag |
| evt_lead_not_l1 | input | 1 | First readout not from the first layer flag |
| evt_layer_skip | input | 1 | Readout out of layer order flag |
| q_pop | input | 4 | Per-queue pop strobes |
| q_rdata | output | 4*DATA_W | Per-queue head entry |
| q_empty | output | 4 | Per-queue empty flags |
| q_ovf | output | 4 | Per-queue sticky overflow bits |
| total_cnt | output | CNT_W | Total accepted events |
| class_cnt | output | 4*CNT_W | Per-class event counts |
| dup_cnt | output | CNT_W | Duplicate first-layer count |
| lead_cnt | output | CNT_W | Wrong first readout count |
| skip_cnt | output | CNT_W | Out-of-layer-order count |

## Verification
The bench uses several input patterns, and each one separates a different class of fault:
- One event of each class, with invalid codes interleaved, shows whether the class decode routes each event to the right queue.
- A burst into a single queue, drained in order, shows whether the pointers keep arrival order.
- Overfilling a queue, and pushing to it during a pop, separates "drop the new event" from "overwrite the oldest or newest entry". It also shows that the class counter keeps counting dropped events.
- Flag combinations on invalid-class events show that the anomaly counters are independent of routing.
- A long run of events exposes counter wrap.
- A frame clear that coincides with an event and a pop shows that the clear takes priority.

// File: rtl/evs_pkg.sv
package evs_pkg;
    localparam int NUM_Q = 4;
    localparam int CLS_W = 3;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_HOLDING = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;
endpackage

// File: rtl/evs_sat_ctr.sv
module evs_sat_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   q <= '0;
        else if (clr)                 q <= '0;
        else if (inc && (q != '1))    q <= q + W'(1);
    end

    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && q == '1) |=> q == '1);
    assert_ctr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);
endmodule

// File: rtl/evs_fifo.sv
module evs_fifo
    import evs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              ovf
);
    // DEPTH must be a power of two so the pointers wrap by themselves.
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    q_state_e          st, st_nx;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt;
    logic              do_push, do_pop;

    assign do_push = push && (st != Q_FULL) && !clr;
    assign do_pop  = pop && (st != Q_EMPTY) && !clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= Q_EMPTY;
        else        st <= st_nx;
    end

    // Transitions: FILL, TOP, DRAIN, RELIEVE, FLUSH
    always_comb begin
        st_nx = st;
        unique case (st)
            Q_EMPTY: begin
                if (do_push) st_nx = Q_HOLDING;
            end
            Q_HOLDING: begin
                if (do_push && !do_pop && cnt == CW'(DEPTH - 1))
                    st_nx = Q_FULL;
                else if (do_pop && !do_push && cnt == CW'(1))
                    st_nx = Q_EMPTY;
            end
            Q_FULL: begin
                if (do_pop) st_nx = Q_HOLDING;
            end
            default: st_nx = Q_EMPTY;
        endcase
        if (clr) st_nx = Q_EMPTY;
    end

    // Outputs
    always_comb begin
        empty = (st == Q_EMPTY);
        rdata = mem[rd_ptr];
    end

    // Pointers, occupancy and overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            if (push && st == Q_FULL) ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assert_drop_keeps_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_FULL && push && !clr) |=> $stable(wr_ptr));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_FULL && push && !clr) |=> ovf);
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_EMPTY && pop && !push && !clr) |=> empty);
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !ovf));
endmodule

// File: rtl/evs_sorter.sv
module evs_sorter
    import evs_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_clr,
    input  logic                    evt_valid,
    input  logic [CLS_W-1:0]        evt_class,
    input  logic [DATA_W-1:0]       evt_data,
    input  logic                    evt_dup_l1,
    input  logic                    evt_lead_not_l1,
    input  logic                    evt_layer_skip,
    input  logic [NUM_Q-1:0]        q_pop,
    output logic [NUM_Q*DATA_W-1:0] q_rdata,
    output logic [NUM_Q-1:0]        q_empty,
    output logic [NUM_Q-1:0]        q_ovf,
    output logic [CNT_W-1:0]        total_cnt,
    output logic [NUM_Q*CNT_W-1:0]  class_cnt,
    output logic [CNT_W-1:0]        dup_cnt,
    output logic [CNT_W-1:0]        lead_cnt,
    output logic [CNT_W-1:0]        skip_cnt
);
    logic accept;
    logic cls_ok;

    assign accept = evt_valid && !frame_clr;   // frame clear wins (R9)
    assign cls_ok = (evt_class[CLS_W-1] == 1'b0); // codes 4..7 invalid (R1)

    for (genvar qi = 0; qi < NUM_Q; qi++) begin : g_q
        logic sel;
        assign sel = accept && cls_ok && (evt_class[1:0] == 2'(qi));

        evs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (frame_clr),
            .push  (sel),
            .pop   (q_pop[qi]),
            .wdata (evt_data),
            .rdata (q_rdata[qi*DATA_W +: DATA_W]),
            .empty (q_empty[qi]),
            .ovf   (q_ovf[qi])
        );

        evs_sat_ctr #(.W(CNT_W)) u_cls (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (frame_clr),
            .inc   (sel),
            .q     (class_cnt[qi*CNT_W +: CNT_W])
        );
    end

    evs_sat_ctr #(.W(CNT_W)) u_total (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr), .inc(accept), .q(total_cnt));
    evs_sat_ctr #(.W(CNT_W)) u_dup (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr),
        .inc(accept && evt_dup_l1), .q(dup_cnt));
    evs_sat_ctr #(.W(CNT_W)) u_lead (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr),
        .inc(accept && evt_lead_not_l1), .q(lead_cnt));
    evs_sat_ctr #(.W(CNT_W)) u_skip (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr),
        .inc(accept && evt_layer_skip), .q(skip_cnt));

    assert_total_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && total_cnt != '1) |=> total_cnt == $past(total_cnt) + CNT_W'(1));
    assert_invalid_not_queued_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cls_ok && q_pop == '0) |=> $stable(q_empty));
    assert_frame_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> (total_cnt == '0 && q_empty == '1 && q_ovf == '0));
endmodule

// File: tb/evs_sorter_test.sv
module evs_sorter_test;
    localparam int DW = 24;
    localparam int DEP = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clr = 1'b0;
    logic evt_valid = 1'b0;
    logic [2:0] evt_class = '0;
    logic [DW-1:0] evt_data = '0;
    logic f_dup = 1'b0, f_lead = 1'b0, f_skip = 1'b0;
    logic [3:0] q_pop = '0;
    logic [4*DW-1:0] q_rdata;
    logic [3:0] q_empty, q_ovf;
    logic [CW-1:0] total_cnt, dup_cnt, lead_cnt, skip_cnt;
    logic [4*CW-1:0] class_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evs_sorter #(.DATA_W(DW), .DEPTH(DEP), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr),
        .evt_valid(evt_valid), .evt_class(evt_class), .evt_data(evt_data),
        .evt_dup_l1(f_dup), .evt_lead_not_l1(f_lead), .evt_layer_skip(f_skip),
        .q_pop(q_pop), .q_rdata(q_rdata), .q_empty(q_empty), .q_ovf(q_ovf),
        .total_cnt(total_cnt), .class_cnt(class_cnt),
        .dup_cnt(dup_cnt), .lead_cnt(lead_cnt), .skip_cnt(skip_cnt));

    function automatic logic [DW-1:0] head(input int i);
        return q_rdata[i*DW +: DW];
    endfunction
    function automatic logic [CW-1:0] ccnt(input int i);
        return class_cnt[i*CW +: CW];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] c, input logic [DW-1:0] d, input logic [2:0] fl);
        @(negedge clk);
        evt_valid = 1'b1; evt_class = c; evt_data = d;
        {f_dup, f_lead, f_skip} = fl;
        @(negedge clk);
        evt_valid = 1'b0; {f_dup, f_lead, f_skip} = 3'b000;
    endtask

    task automatic pop_q(input int i);
        @(negedge clk);
        q_pop[i] = 1'b1;
        @(negedge clk);
        q_pop = '0;
    endtask

    task automatic push_pop(input logic [2:0] c, input logic [DW-1:0] d, input int i);
        @(negedge clk);
        evt_valid = 1'b1; evt_class = c; evt_data = d; q_pop[i] = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; q_pop = '0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_clr = 1'b1;
        @(negedge clk);
        frame_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9", "reset empty", 32'(q_empty), 32'hF);
        chk("R9", "reset ovf", 32'(q_ovf), 32'h0);
        chk("R5", "reset total", 32'(total_cnt), 0);
        chk("R6", "reset class", 32'(class_cnt), 0);
    endtask

    task automatic t_routing();
        frame();
        for (int c = 0; c < 4; c++) send(3'(c), DW'(24'h0C0 + c), 3'b000);
        send(3'b111, 24'hDEAD01, 3'b000);
        send(3'b101, 24'hDEAD02, 3'b000);
        chk("R1", "all four hold data", 32'(q_empty), 32'h0);
        for (int c = 0; c < 4; c++) begin
            chk("R1", "head per class", 32'(head(c)), 32'h0C0 + c);
            chk("R6", "one per class", 32'(ccnt(c)), 1);
        end
        chk("R5", "total includes invalid", 32'(total_cnt), 6);
        for (int c = 0; c < 4; c++) pop_q(c);
        chk("R1", "invalid codes not queued", 32'(q_empty), 32'hF);
    endtask

    task automatic t_order();
        frame();
        for (int k = 0; k < 5; k++) send(3'd2, DW'(24'hA00 + k), 3'b000);
        chk("R6", "class2 count", 32'(ccnt(2)), 5);
        for (int k = 0; k < 5; k++) begin
            chk("R2", "fifo order", 32'(head(2)), 32'hA00 + k);
            pop_q(2);
        end
        chk("R2", "drained", 32'(q_empty[2]), 1);
    endtask

    task automatic t_overflow();
        frame();
        for (int k = 0; k < 16; k++) send(3'd1, DW'(24'h100 + k), 3'b000);
        chk("R4", "no ovf at exactly full", 32'(q_ovf), 0);
        send(3'd1, 24'h110, 3'b000);
        chk("R4", "ovf after first drop", 32'(q_ovf), 32'h2);
        send(3'd1, 24'h111, 3'b000);
        chk("R6", "class counts drops", 32'(ccnt(1)), 18);
        chk("R5", "total counts drops", 32'(total_cnt), 18);
        push_pop(3'd1, 24'hBEEF, 1);
        chk("R3", "head after pop when full", 32'(head(1)), 32'h101);
        chk("R6", "class counts full push", 32'(ccnt(1)), 19);
        for (int k = 1; k < 16; k++) begin
            chk("R3", "kept entries", 32'(head(1)), 32'h100 + k);
            pop_q(1);
        end
        chk("R3", "dropped events absent", 32'(q_empty[1]), 1);
        chk("R4", "ovf sticky after drain", 32'(q_ovf[1]), 1);
    endtask

    task automatic t_frame_priority();
        send(3'd0, 24'h55, 3'b000);
        @(negedge clk);
        frame_clr = 1'b1; evt_valid = 1'b1; evt_class = 3'd0; evt_data = 24'h66;
        f_dup = 1'b1; q_pop[0] = 1'b1;
        @(negedge clk);
        frame_clr = 1'b0; evt_valid = 1'b0; f_dup = 1'b0; q_pop = '0;
        chk("R9", "queues emptied", 32'(q_empty), 32'hF);
        chk("R9", "ovf cleared", 32'(q_ovf), 0);
        chk("R9", "total cleared, event uncounted", 32'(total_cnt), 0);
        chk("R9", "class cleared", 32'(class_cnt), 0);
        chk("R9", "dup uncounted", 32'(dup_cnt), 0);
    endtask

    task automatic t_anomaly();
        frame();
        send(3'b111, 24'h1, 3'b100);
        send(3'b111, 24'h2, 3'b010);
        send(3'b111, 24'h3, 3'b001);
        send(3'b111, 24'h4, 3'b111);
        send(3'b111, 24'h5, 3'b000);
        chk("R7", "dup count", 32'(dup_cnt), 2);
        chk("R7", "lead count", 32'(lead_cnt), 2);
        chk("R7", "skip count", 32'(skip_cnt), 2);
        chk("R5", "total", 32'(total_cnt), 5);
        chk("R1", "no class counted", 32'(class_cnt), 0);
    endtask

    task automatic t_pop_empty();
        frame();
        pop_q(0);
        pop_q(0);
        chk("R10", "still empty", 32'(q_empty[0]), 1);
        send(3'd0, 24'h777, 3'b000);
        chk("R10", "head after empty pops", 32'(head(0)), 32'h777);
        chk("R10", "not empty", 32'(q_empty[0]), 0);
        pop_q(0);
        chk("R10", "empty again", 32'(q_empty[0]), 1);
        push_pop(3'd3, 24'h333, 3);
        chk("R10", "push kept on empty pop", 32'(head(3)), 32'h333);
        chk("R10", "q3 not empty", 32'(q_empty[3]), 0);
    endtask

    task automatic t_saturate();
        frame();
        for (int k = 0; k < 260; k++) send(3'd3, DW'(k), 3'b100);
        chk("R8", "total saturates", 32'(total_cnt), 255);
        chk("R8", "class saturates", 32'(ccnt(3)), 255);
        chk("R8", "dup saturates", 32'(dup_cnt), 255);
        chk("R6", "other class untouched", 32'(ccnt(0)), 0);
        chk("R4", "ovf on q3", 32'(q_ovf), 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_routing();
        t_order();
        t_overflow();
        t_frame_priority();
        t_anomaly();
        t_pop_empty();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule